// File: doc/BRIEF.md
# Host Reset and Shutdown Controller

This block takes the host-control requests that reach the platform from outside the power sequencer and turns them into three pin-level actions toward the host processor and its platform hub. A warm-reset request produces one active-low system reset pulse whose width is set in milliseconds. A forced-shutdown request holds a virtual power-button press until the sequencer reports that the host has settled in S5. A throttle level is passed to a processor-hot line whose polarity is chosen by a parameter.

The sequencer supplies its current state as a 4-bit code, and a one-cycle millisecond tick times the reset pulse. Both the reset pulse and the forced shutdown are refused while the host is already off. The throttle level is applied only while the host runs in S0; in every other state the processor-hot line keeps its last value.

Top module: `hrc_host_ctrl`

## Requirements
- R1: An accepted warm-reset request drives `sys_rst_n` low from the clock edge that samples it. The line returns high at the edge that samples the PULSE_MS-th `ms_tick` seen while the line is already low (default PULSE_MS = 32). A tick in the request cycle does not count.
- R2: A warm-reset request is ignored while the host is off. The state code is 0 = G3, 1 = G3 to S5, 2 = S5, 3 = S5 to S3, 4 = S3, 5 = S3 to S0, 6 = S0, 7 = S0 to S3, 8 = S3 to S5, 9 = S5 to G3. The off codes are 0, 1, 2 and 9.
- R3: A forced-shutdown request sampled while the host is not off sets `btn_press` and `shutdown_pending` at that edge. A request in an off state changes nothing.
- R4: While `btn_press` is set, both it and `shutdown_pending` clear at the edge that samples state code 2 (S5). In any other state the press is held.
- R5: With state code 6 (S0), `prochot` takes the throttle level at the next edge. In every other state `prochot` keeps its value.
- R6: With HOT_ACTIVE_LOW = 1, `prochot` carries the inverted throttle level, and its inactive (reset) level is 1.
- R7: A warm-reset request that arrives while a pulse is in progress is ignored. It neither restarts nor lengthens the pulse.
- R8: While synchronous reset is active, `sys_rst_n` is 1, `btn_press` and `shutdown_pending` are 0, and `prochot` is at its inactive level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle millisecond tick |
| pwr_state | input | 4 | Current sequencer state code |
| warm_rst_req | input | 1 | Warm-reset request strobe |
| force_off_req | input | 1 | Forced-shutdown request strobe |
| throttle | input | 1 | Throttle request level |
| sys_rst_n | output | 1 | Active-low system reset toward the host |
| btn_press | output | 1 | Virtual power-button press toward the platform hub |
| prochot | output | 1 | Processor-hot line |
| shutdown_pending | output | 1 | Forced shutdown in progress |

## Verification
The bench goes after the gating cases: reset and shutdown requests in each of the four off codes. A design that tests only G3 would pulse or press the button from S5 or from a transition state. It repeats reset requests during a live pulse, where a retriggering design would stretch the low time past PULSE_MS ticks. It walks a pressed button through S3 and the S3-to-S5 transition before S5, so a design that released early or never released shows up. It changes the throttle outside S0 on both polarities, where a design that followed the input would move `prochot`. Random traffic then mixes ticks, strobes and state changes against a cycle model built from the requirements.

// File: rtl/hrc_pkg.sv
`timescale 1ns/1ps
package hrc_pkg;

    typedef enum logic [3:0] {
        PS_G3    = 4'd0,
        PS_G3_S5 = 4'd1,
        PS_S5    = 4'd2,
        PS_S5_S3 = 4'd3,
        PS_S3    = 4'd4,
        PS_S3_S0 = 4'd5,
        PS_S0    = 4'd6,
        PS_S0_S3 = 4'd7,
        PS_S3_S5 = 4'd8,
        PS_S5_G3 = 4'd9
    } pwr_state_e;

    typedef struct packed {
        logic warm_rst;
        logic force_off;
        logic throttle;
    } host_req_t;

    function automatic logic host_is_off(input logic [3:0] st);
        return (st == PS_G3) || (st == PS_G3_S5) ||
               (st == PS_S5) || (st == PS_S5_G3);
    endfunction

endpackage

// File: rtl/hrc_reset_pulse.sv
`timescale 1ns/1ps
module hrc_reset_pulse #(
    parameter int PULSE_MS = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic req,
    input  logic host_off,
    output logic rst_n_o
);
    localparam int CNT_W = $clog2(PULSE_MS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_MS - 1);

    logic             active;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (!active) begin
            if (req && !host_off) begin
                active <= 1'b1;
                cnt    <= '0;
            end
        end else if (tick) begin
            if (cnt == LAST) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign rst_n_o = ~active;
endmodule

// File: rtl/hrc_shutdown_ctl.sv
`timescale 1ns/1ps
module hrc_shutdown_ctl (
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       host_off,
    input  logic [3:0] state,
    output logic       press_o
);
    import hrc_pkg::*;

    logic pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (pending && (state == PS_S5)) begin
            pending <= 1'b0;
        end else if (req && !host_off) begin
            pending <= 1'b1;
        end
    end

    assign press_o = pending;
endmodule

// File: rtl/hrc_throttle_map.sv
`timescale 1ns/1ps
module hrc_throttle_map #(
    parameter bit HOT_ACTIVE_LOW = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       throttle,
    input  logic [3:0] state,
    output logic       hot_o
);
    import hrc_pkg::*;

    localparam logic IDLE_LVL = HOT_ACTIVE_LOW;

    logic level;
    logic hot_q;

    generate
        if (HOT_ACTIVE_LOW) begin : g_inv
            assign level = ~throttle;
        end else begin : g_pass
            assign level = throttle;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            hot_q <= IDLE_LVL;
        end else if (state == PS_S0) begin
            hot_q <= level;
        end
    end

    assign hot_o = hot_q;
endmodule

// File: rtl/hrc_host_ctrl.sv
`timescale 1ns/1ps
module hrc_host_ctrl #(
    parameter int PULSE_MS       = 32,
    parameter bit HOT_ACTIVE_LOW = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ms_tick,
    input  logic [3:0] pwr_state,
    input  logic       warm_rst_req,
    input  logic       force_off_req,
    input  logic       throttle,
    output logic       sys_rst_n,
    output logic       btn_press,
    output logic       prochot,
    output logic       shutdown_pending
);
    import hrc_pkg::*;

    host_req_t req;
    logic      off;
    logic      press;

    assign req = '{warm_rst: warm_rst_req, force_off: force_off_req, throttle: throttle};
    assign off = host_is_off(pwr_state);

    hrc_reset_pulse #(.PULSE_MS(PULSE_MS)) i_pulse (
        .clk(clk), .rst(rst), .tick(ms_tick), .req(req.warm_rst),
        .host_off(off), .rst_n_o(sys_rst_n)
    );

    hrc_shutdown_ctl i_shut (
        .clk(clk), .rst(rst), .req(req.force_off), .host_off(off),
        .state(pwr_state), .press_o(press)
    );

    hrc_throttle_map #(.HOT_ACTIVE_LOW(HOT_ACTIVE_LOW)) i_hot (
        .clk(clk), .rst(rst), .throttle(req.throttle), .state(pwr_state),
        .hot_o(prochot)
    );

    assign btn_press        = press;
    assign shutdown_pending = press;
endmodule

// File: rtl/hrc_host_ctrl_chk.sv
`timescale 1ns/1ps
module hrc_host_ctrl_chk #(
    parameter int PULSE_MS = 32
) (
    input logic       clk,
    input logic       rst,
    input logic       ms_tick,
    input logic [3:0] pwr_state,
    input logic       warm_rst_req,
    input logic       force_off_req,
    input logic       sys_rst_n,
    input logic       btn_press,
    input logic       prochot
);
    import hrc_pkg::*;

    localparam int CW = $clog2(PULSE_MS + 2);

    logic [CW-1:0] low_ticks;

    always_ff @(posedge clk) begin
        if (rst || sys_rst_n) low_ticks <= '0;
        else if (ms_tick)     low_ticks <= low_ticks + 1'b1;
    end

    p_pulse_len_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_n) |-> (low_ticks == CW'(PULSE_MS)));

    p_fall_cause_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_rst_n) |-> ($past(warm_rst_req) && !host_is_off($past(pwr_state))));

    p_off_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (sys_rst_n && warm_rst_req && host_is_off(pwr_state)) |=> sys_rst_n);

    p_no_retrigger_r7: assert property (@(posedge clk) disable iff (rst)
        (!sys_rst_n && ms_tick && low_ticks == CW'(PULSE_MS - 1)) |=> sys_rst_n);

    p_press_r3: assert property (@(posedge clk) disable iff (rst)
        (force_off_req && !host_is_off(pwr_state)) |=> btn_press);

    p_release_r4: assert property (@(posedge clk) disable iff (rst)
        (btn_press && pwr_state == PS_S5) |=> !btn_press);

    p_hot_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (pwr_state != PS_S0) |=> $stable(prochot));
endmodule

bind hrc_host_ctrl hrc_host_ctrl_chk #(.PULSE_MS(PULSE_MS)) i_chk (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .pwr_state(pwr_state),
    .warm_rst_req(warm_rst_req), .force_off_req(force_off_req),
    .sys_rst_n(sys_rst_n), .btn_press(btn_press), .prochot(prochot)
);

// File: tb/test_hrc_host_ctrl.sv
`timescale 1ns/1ps
module test_hrc_host_ctrl;
    localparam int PULSE_MS = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1;
    logic       ms_tick = 1'b0, warm = 1'b0, force_off = 1'b0, thr = 1'b0;
    logic [3:0] pst = 4'd0;
    logic       sys_rst_n, btn_press, prochot, pending;
    logic       sys_rst_n_i, btn_press_i, prochot_i, pending_i;

    hrc_host_ctrl #(.PULSE_MS(PULSE_MS)) i_hrc_host_ctrl (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .pwr_state(pst),
        .warm_rst_req(warm), .force_off_req(force_off), .throttle(thr),
        .sys_rst_n(sys_rst_n), .btn_press(btn_press), .prochot(prochot),
        .shutdown_pending(pending)
    );

    hrc_host_ctrl #(.PULSE_MS(PULSE_MS), .HOT_ACTIVE_LOW(1'b1)) i_hrc_host_ctrl_inv (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .pwr_state(pst),
        .warm_rst_req(warm), .force_off_req(force_off), .throttle(thr),
        .sys_rst_n(sys_rst_n_i), .btn_press(btn_press_i), .prochot(prochot_i),
        .shutdown_pending(pending_i)
    );

    int  checks = 0, fails = 0;
    bit  done = 1'b0;
    bit  rst_drive = 1'b1;
    bit  m_act, m_btn, m_hot, m_hot_inv;
    int  m_cnt;
    logic s_rstn, s_btn, s_pend, s_hot, s_hot_inv;

    function automatic bit off_st(input logic [3:0] s);
        return (s == 4'd0) || (s == 4'd1) || (s == 4'd2) || (s == 4'd9);
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_act = 0; m_cnt = 0; m_btn = 0; m_hot = 0; m_hot_inv = 1;
    endtask

    task automatic cycle(input logic rr, input logic sr, input logic [3:0] st,
                         input logic tk, input logic th);
        @(negedge clk);
        s_rstn = sys_rst_n; s_btn = btn_press; s_pend = pending;
        s_hot = prochot; s_hot_inv = prochot_i;
        if (!rst) begin
            check("R1", "sys_rst_n", sys_rst_n, !m_act);
            check("R3", "btn_press", btn_press, m_btn);
            check("R3", "shutdown_pending", pending, m_btn);
            check("R5", "prochot", prochot, m_hot);
            check("R6", "prochot_inv", prochot_i, m_hot_inv);
        end
        rst = rst_drive; warm = rr; force_off = sr; pst = st; ms_tick = tk; thr = th;
        if (rst_drive) begin
            model_reset();
        end else begin
            if (!m_act) begin
                if (rr && !off_st(st)) begin m_act = 1; m_cnt = 0; end
            end else if (tk) begin
                m_cnt++;
                if (m_cnt == PULSE_MS) m_act = 0;
            end
            if (m_btn && st == 4'd2)       m_btn = 0;
            else if (sr && !off_st(st))    m_btn = 1;
            if (st == 4'd6) begin m_hot = th; m_hot_inv = !th; end
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int low;
        logic [3:0] cur;
        void'($urandom(32'd2718));
        model_reset();
        repeat (3) cycle(1, 1, 4'd6, 1, 1);
        // R8: reset values seen while reset is held
        check("R8", "sys_rst_n", sys_rst_n, 1'b1);
        check("R8", "btn_press", btn_press, 1'b0);
        check("R8", "prochot", prochot, 1'b0);
        check("R8", "prochot_inv", prochot_i, 1'b1);
        rst_drive = 0;
        cycle(0, 0, 4'd0, 0, 0);
        cycle(0, 0, 4'd0, 0, 0);

        // R2: reset requests in every off code leave the line high
        foreach (cur[i]) begin end
        for (int k = 0; k < 4; k++) begin
            logic [3:0] oc;
            oc = (k == 3) ? 4'd9 : 4'(k);
            cycle(1, 0, oc, 1, 0);
            cycle(0, 0, oc, 0, 0);
            check("R2", "sys_rst_n after off request", s_rstn, 1'b1);
            cycle(0, 1, oc, 0, 0);
            cycle(0, 0, oc, 0, 0);
            check("R3", "btn_press after off request", s_btn, 1'b0);
        end

        // R1 / R7: request in S0, repeated requests during pulse, tick every cycle
        low = 0;
        for (int k = 0; k < 60; k++) begin
            cycle(k < 20, 0, 4'd6, 1, 0);
            if (k > 0 && !s_rstn) low++;
        end
        check("R7", "no retrigger, low cycles==32", low == 32, 1'b1);
        check("R1", "line high after pulse", s_rstn, 1'b1);

        // R4: press held through S3 and S3->S5, released in S5
        cycle(0, 1, 4'd6, 0, 0);
        cycle(0, 0, 4'd7, 0, 0);
        check("R3", "press set from S0", s_btn, 1'b1);
        cycle(0, 0, 4'd4, 0, 0);
        cycle(0, 0, 4'd8, 0, 0);
        check("R4", "press held in S3", s_btn, 1'b1);
        cycle(0, 0, 4'd2, 0, 0);
        check("R4", "press held in S3->S5", s_btn, 1'b1);
        cycle(0, 0, 4'd2, 0, 0);
        check("R4", "press released in S5", s_btn, 1'b0);
        check("R4", "pending cleared in S5", s_pend, 1'b0);

        // R5 / R6: throttle only in S0, both polarities
        cycle(0, 0, 4'd6, 0, 1);
        cycle(0, 0, 4'd4, 0, 0);
        check("R5", "prochot follows in S0", s_hot, 1'b1);
        check("R6", "inverted prochot in S0", s_hot_inv, 1'b0);
        cycle(0, 0, 4'd4, 0, 0);
        cycle(0, 0, 4'd3, 0, 1);
        check("R5", "prochot held outside S0", s_hot, 1'b1);
        check("R6", "inverted prochot held", s_hot_inv, 1'b0);

        // random traffic against the cycle model
        cur = 4'd6;
        for (int k = 0; k < 5000; k++) begin
            if ($urandom_range(0, 7) == 0) cur = 4'($urandom_range(0, 9));
            cycle($urandom_range(0, 19) == 0, $urandom_range(0, 29) == 0, cur,
                  $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1);
        end
        cycle(0, 0, cur, 0, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule